// File: doc/BRIEF.md
# Virtual Interrupt Deactivation Handler

This block services writes to a virtual deactivate-interrupt register in a virtualised interrupt controller CPU interface. A write carries an interrupt ID. When the guest runs with priority drop and deactivation split into two steps, the block scans a small array of list entries. These entries are the hypervisor's view of the guest's in-flight interrupts. The block looks for an active entry whose virtual ID equals the written one.

If such an entry exists, the block writes that entry back with only its active bit removed. If the entry is tied to a physical interrupt whose physical ID is a real, non-special number, the block also sends a single-cycle deactivate request for that physical ID. If no entry matches, the block writes the hypervisor control word back with its end-of-interrupt counter advanced by one, so that the hypervisor can see the guest retiring an interrupt it does not track.

Every result is registered and appears one cycle after the write strobe. The parent that owns the list array and the control word applies the write-backs.

Top module: `vdeact_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted write, every output valid and every output data field is zero.
- R2: The interrupt ID is bits [23:0] of the write data. Bits [31:24] do not affect any result.
- R3: A write whose ID is greater than or equal to `numIntr` produces no output at all.
- R4: A write while `splitMode` is low produces no output, and it leaves the list entries unchanged.
- R5: List entry state is 2 bits with bit 1 as the active flag: 00 invalid, 01 pending, 10 active, 11 active and pending. The matched entry is the lowest-index entry with the active flag set and a virtual ID equal to the written ID. Entries that are only pending never match.
- R6: On a match, the entry write-back carries the matched index and the old state with bit 1 cleared. So 11 becomes 01 and 10 becomes 00.
- R7: On a match with the hardware flag set and a physical ID below 1020, `physDeactValid` pulses for one cycle and `physDeactId` carries the entry's physical ID.
- R8: On a match whose entry has the hardware flag clear, or has a physical ID of 1020 or above, no physical request is made. The entry is still written back.
- R9: On an accepted write with no match, `hcrWbData` equals `hcrIn` with field [31:27] incremented modulo 32 and all other bits unchanged.
- R10: Each result appears exactly one cycle after the strobe. An accepted write produces either an entry write-back or a control write-back, never both. Writes on consecutive cycles each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dirWrEn | input | 1 | Deactivate-register write strobe |
| dirWrData | input | WR_W | Written value; ID in the low ID_W bits |
| splitMode | input | 1 | Split priority-drop/deactivate mode |
| numIntr | input | ID_W+1 | Number of implemented interrupt IDs |
| entryState | input | 2*NUM_ENTRIES | Per-entry 2-bit state, entry i at [2i+1:2i] |
| entryVid | input | NUM_ENTRIES*ID_W | Per-entry virtual ID |
| entryHw | input | NUM_ENTRIES | Per-entry hardware-linked flag |
| entryPid | input | NUM_ENTRIES*PID_W | Per-entry physical ID |
| hcrIn | input | HCR_W | Current hypervisor control word |
| entryWbValid | output | 1 | Entry write-back strobe |
| entryWbIdx | output | IDX_W | Index of the entry to write back |
| entryWbState | output | 2 | New state for that entry |
| hcrWbValid | output | 1 | Control word write-back strobe |
| hcrWbData | output | HCR_W | New control word value |
| physDeactValid | output | 1 | Physical deactivate request pulse |
| physDeactId | output | PID_W | Physical ID to deactivate |

## Verification
Every result is due in the clock cycle that follows the cycle in which the write strobe is high. The entry write-back, the control write-back and the physical request all become visible after the first rising edge that samples the strobe.

The driver task computes the expected outcome of each write from its own model of the list array and the control word, and queues it. The monitor samples 5 ns after each rising edge. It pops one queued item in the cycle after each strobe and compares all three outputs against it. In any cycle with nothing queued, any valid output is flagged as an error.

The model applies each write-back only at the next drive point. The design therefore sees the old state during the strobe cycle, as it would in the real system.

// File: rtl/vdeact_pkg.sv
package vdeact_pkg;

  // Strobes from control to datapath, one field per result kind.
  typedef struct packed {
    logic clrEntry;   // write back the matched entry with active cleared
    logic bumpCount;  // write back control word with counter + 1
    logic sendPhys;   // issue physical deactivate pulse
  } ctrlStrobes_t;

  localparam int STATE_W    = 2;
  localparam int ACTIVE_BIT = 1;
  localparam int PEND_BIT   = 0;

endpackage

// File: rtl/vdeact_ctrl.sv
module vdeact_ctrl
  import vdeact_pkg::*;
#(
  parameter int ID_W      = 24,
  parameter int PID_W     = 10,
  parameter int PID_LIMIT = 1020
) (
  input  logic             wrEn,
  input  logic [ID_W-1:0]  wrId,
  input  logic             splitMode,
  input  logic [ID_W:0]    numIntr,
  input  logic             matchFound,
  input  logic             matchHw,
  input  logic [PID_W-1:0] matchPid,
  output ctrlStrobes_t     strobes
);

  logic idInRange;
  logic accepted;
  logic pidUsable;

  // R3: IDs at or above the implemented count are dropped
  assign idInRange = ({1'b0, wrId} < numIntr);
  // R4: only honoured in split mode
  assign accepted  = wrEn && splitMode && idInRange;
  // R7/R8: special physical IDs are never forwarded
  assign pidUsable = matchHw && (matchPid < PID_W'(PID_LIMIT));

  always_comb begin
    strobes           = '0;
    strobes.clrEntry  = accepted && matchFound;
    strobes.bumpCount = accepted && !matchFound;
    strobes.sendPhys  = accepted && matchFound && pidUsable;
  end

endmodule

// File: rtl/vdeact_datapath.sv
module vdeact_datapath
  import vdeact_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ID_W        = 24,
  parameter int PID_W       = 10,
  parameter int HCR_W       = 32,
  parameter int EOI_LSB     = 27,
  parameter int EOI_W       = 5,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ID_W-1:0]              wrId,
  input  logic [STATE_W*NUM_ENTRIES-1:0] entryState,
  input  logic [NUM_ENTRIES*ID_W-1:0]  entryVid,
  input  logic [NUM_ENTRIES-1:0]       entryHw,
  input  logic [NUM_ENTRIES*PID_W-1:0] entryPid,
  input  logic [HCR_W-1:0]             hcrIn,
  input  ctrlStrobes_t                 strobes,
  output logic                         matchFound,
  output logic                         matchHw,
  output logic [PID_W-1:0]             matchPid,
  output logic                         entryWbValid,
  output logic [IDX_W-1:0]             entryWbIdx,
  output logic [STATE_W-1:0]           entryWbState,
  output logic                         hcrWbValid,
  output logic [HCR_W-1:0]             hcrWbData,
  output logic                         physDeactValid,
  output logic [PID_W-1:0]             physDeactId
);

  logic [NUM_ENTRIES-1:0] hitVec;
  logic [IDX_W-1:0]       matchIdx;
  logic [STATE_W-1:0]     matchState;
  logic [STATE_W-1:0]     clearedState;
  logic [HCR_W-1:0]       bumpedHcr;

  // R5: per-entry comparators, one per list entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = entryState[STATE_W*g + ACTIVE_BIT] &&
                       (entryVid[g*ID_W +: ID_W] == wrId);
  end

  // R5: lowest index wins
  always_comb begin
    matchIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) matchIdx = IDX_W'(i);
    end
  end

  assign matchFound = |hitVec;
  assign matchHw    = entryHw[matchIdx];
  assign matchPid   = entryPid[matchIdx*PID_W +: PID_W];
  assign matchState = entryState[matchIdx*STATE_W +: STATE_W];

  // R6: drop only the active flag
  always_comb begin
    clearedState             = matchState;
    clearedState[ACTIVE_BIT] = 1'b0;
  end

  // R9: counter field advances, wraps naturally
  always_comb begin
    bumpedHcr                      = hcrIn;
    bumpedHcr[EOI_LSB +: EOI_W]    = hcrIn[EOI_LSB +: EOI_W] + EOI_W'(1);
  end

  // R1/R10: all results registered, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryWbValid   <= 1'b0;
      entryWbIdx     <= '0;
      entryWbState   <= '0;
      hcrWbValid     <= 1'b0;
      hcrWbData      <= '0;
      physDeactValid <= 1'b0;
      physDeactId    <= '0;
    end else begin
      entryWbValid   <= strobes.clrEntry;
      entryWbIdx     <= strobes.clrEntry ? matchIdx : '0;
      entryWbState   <= strobes.clrEntry ? clearedState : '0;
      hcrWbValid     <= strobes.bumpCount;
      hcrWbData      <= strobes.bumpCount ? bumpedHcr : '0;
      physDeactValid <= strobes.sendPhys;
      physDeactId    <= strobes.sendPhys ? matchPid : '0;
    end
  end

endmodule

// File: rtl/vdeact_unit.sv
module vdeact_unit
  import vdeact_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int WR_W        = 32,
  parameter int ID_W        = 24,
  parameter int PID_W       = 10,
  parameter int PID_LIMIT   = 1020,
  parameter int HCR_W       = 32,
  parameter int EOI_LSB     = 27,
  parameter int EOI_W       = 5,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           dirWrEn,
  input  logic [WR_W-1:0]                dirWrData,
  input  logic                           splitMode,
  input  logic [ID_W:0]                  numIntr,
  input  logic [STATE_W*NUM_ENTRIES-1:0] entryState,
  input  logic [NUM_ENTRIES*ID_W-1:0]    entryVid,
  input  logic [NUM_ENTRIES-1:0]         entryHw,
  input  logic [NUM_ENTRIES*PID_W-1:0]   entryPid,
  input  logic [HCR_W-1:0]               hcrIn,
  output logic                           entryWbValid,
  output logic [IDX_W-1:0]               entryWbIdx,
  output logic [STATE_W-1:0]             entryWbState,
  output logic                           hcrWbValid,
  output logic [HCR_W-1:0]               hcrWbData,
  output logic                           physDeactValid,
  output logic [PID_W-1:0]               physDeactId
);

  logic [ID_W-1:0]  wrId;
  logic             matchFound;
  logic             matchHw;
  logic [PID_W-1:0] matchPid;
  ctrlStrobes_t     strobes;

  // R2: only the low bits name the interrupt
  assign wrId = dirWrData[ID_W-1:0];

  vdeact_ctrl #(
    .ID_W      (ID_W),
    .PID_W     (PID_W),
    .PID_LIMIT (PID_LIMIT)
  ) u_ctrl (
    .wrEn       (dirWrEn),
    .wrId       (wrId),
    .splitMode  (splitMode),
    .numIntr    (numIntr),
    .matchFound (matchFound),
    .matchHw    (matchHw),
    .matchPid   (matchPid),
    .strobes    (strobes)
  );

  vdeact_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ID_W        (ID_W),
    .PID_W       (PID_W),
    .HCR_W       (HCR_W),
    .EOI_LSB     (EOI_LSB),
    .EOI_W       (EOI_W),
    .IDX_W       (IDX_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .wrId           (wrId),
    .entryState     (entryState),
    .entryVid       (entryVid),
    .entryHw        (entryHw),
    .entryPid       (entryPid),
    .hcrIn          (hcrIn),
    .strobes        (strobes),
    .matchFound     (matchFound),
    .matchHw        (matchHw),
    .matchPid       (matchPid),
    .entryWbValid   (entryWbValid),
    .entryWbIdx     (entryWbIdx),
    .entryWbState   (entryWbState),
    .hcrWbValid     (hcrWbValid),
    .hcrWbData      (hcrWbData),
    .physDeactValid (physDeactValid),
    .physDeactId    (physDeactId)
  );

endmodule

// File: rtl/vdeact_checker.sv
module vdeact_checker #(
  parameter int WR_W      = 32,
  parameter int ID_W      = 24,
  parameter int PID_W     = 10,
  parameter int PID_LIMIT = 1020,
  parameter int HCR_W     = 32,
  parameter int EOI_LSB   = 27,
  parameter int EOI_W     = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             dirWrEn,
  input logic [WR_W-1:0]  dirWrData,
  input logic             splitMode,
  input logic [ID_W:0]    numIntr,
  input logic [HCR_W-1:0] hcrIn,
  input logic             entryWbValid,
  input logic [1:0]       entryWbState,
  input logic             hcrWbValid,
  input logic [HCR_W-1:0] hcrWbData,
  input logic             physDeactValid,
  input logic [PID_W-1:0] physDeactId
);

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(entryWbValid && hcrWbValid));

  // R10
  result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryWbValid || hcrWbValid || physDeactValid) |-> $past(dirWrEn));

  // R4
  split_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrEn && !splitMode) |=> (!entryWbValid && !hcrWbValid && !physDeactValid));

  // R3
  out_of_range_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirWrEn && ({1'b0, dirWrData[ID_W-1:0]} >= numIntr))
      |=> (!entryWbValid && !hcrWbValid && !physDeactValid));

  // R6
  active_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryWbValid |-> !entryWbState[1]);

  // R7
  phys_with_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    physDeactValid |-> (entryWbValid && (physDeactId < PID_W'(PID_LIMIT))));

  // R9
  count_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
    hcrWbValid |-> (hcrWbData[EOI_LSB +: EOI_W] ==
                    EOI_W'($past(hcrIn[EOI_LSB +: EOI_W]) + EOI_W'(1))));

  // R9
  other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    hcrWbValid |-> (hcrWbData[EOI_LSB-1:0] == $past(hcrIn[EOI_LSB-1:0])));

endmodule

bind vdeact_unit vdeact_checker #(
  .WR_W      (WR_W),
  .ID_W      (ID_W),
  .PID_W     (PID_W),
  .PID_LIMIT (PID_LIMIT),
  .HCR_W     (HCR_W),
  .EOI_LSB   (EOI_LSB),
  .EOI_W     (EOI_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .dirWrEn        (dirWrEn),
  .dirWrData      (dirWrData),
  .splitMode      (splitMode),
  .numIntr        (numIntr),
  .hcrIn          (hcrIn),
  .entryWbValid   (entryWbValid),
  .entryWbState   (entryWbState),
  .hcrWbValid     (hcrWbValid),
  .hcrWbData      (hcrWbData),
  .physDeactValid (physDeactValid),
  .physDeactId    (physDeactId)
);

// File: tb/vdeact_unit_tb.sv
module vdeact_unit_tb;

  localparam int N = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dirWrEn = 1'b0;
  logic [31:0]       dirWrData = '0;
  logic              splitMode = 1'b1;
  logic [24:0]       numIntr = 25'd64;
  logic [2*N-1:0]    entryState;
  logic [N*24-1:0]   entryVid;
  logic [N-1:0]      entryHw;
  logic [N*10-1:0]   entryPid;
  logic [31:0]       hcrIn;
  logic              entryWbValid;
  logic [1:0]        entryWbIdx;
  logic [1:0]        entryWbState;
  logic              hcrWbValid;
  logic [31:0]       hcrWbData;
  logic              physDeactValid;
  logic [9:0]        physDeactId;

  always #10 clk = ~clk;

  // bench model of the parent's storage
  logic [1:0]  mState [N];
  logic [23:0] mVid   [N];
  logic        mHw    [N];
  logic [9:0]  mPid   [N];
  logic [31:0] mHcr;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      entryState[2*i +: 2]  = mState[i];
      entryVid[24*i +: 24]  = mVid[i];
      entryHw[i]            = mHw[i];
      entryPid[10*i +: 10]  = mPid[i];
    end
    hcrIn = mHcr;
  end

  vdeact_unit u_dut (
    .clk(clk), .rstN(rstN), .dirWrEn(dirWrEn), .dirWrData(dirWrData),
    .splitMode(splitMode), .numIntr(numIntr), .entryState(entryState),
    .entryVid(entryVid), .entryHw(entryHw), .entryPid(entryPid), .hcrIn(hcrIn),
    .entryWbValid(entryWbValid), .entryWbIdx(entryWbIdx), .entryWbState(entryWbState),
    .hcrWbValid(hcrWbValid), .hcrWbData(hcrWbData),
    .physDeactValid(physDeactValid), .physDeactId(physDeactId)
  );

  typedef struct {
    bit          ent;
    int          idx;
    logic [1:0]  st;
    bit          hcrV;
    logic [31:0] hcr;
    bit          phV;
    logic [9:0]  pid;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // deferred write-back from the previous write
  bit          pendEnt = 1'b0;
  int          pendIdx = 0;
  logic [1:0]  pendSt  = '0;
  bit          pendHcrV = 1'b0;
  logic [31:0] pendHcr = '0;

  task automatic applyPending();
    if (pendEnt) mState[pendIdx] = pendSt;
    if (pendHcrV) mHcr = pendHcr;
    pendEnt  = 1'b0;
    pendHcrV = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      applyPending();
      dirWrEn = 1'b0;
    end
  endtask

  task automatic doWrite(input logic [31:0] data, input string tag);
    exp_t e;
    logic [23:0] id;
    bit found;
    int idx;
    @(negedge clk);
    applyPending();
    id = data[23:0];
    e.ent = 0; e.idx = 0; e.st = '0; e.hcrV = 0; e.hcr = '0;
    e.phV = 0; e.pid = '0; e.tag = tag;
    found = 0; idx = 0;
    if (splitMode && ({1'b0, id} < numIntr)) begin
      for (int i = 0; i < N; i++) begin
        if (!found && mState[i][1] && mVid[i] == id) begin
          found = 1; idx = i;
        end
      end
      if (found) begin
        e.ent = 1; e.idx = idx; e.st = {1'b0, mState[idx][0]};
        if (mHw[idx] && mPid[idx] < 10'd1020) begin
          e.phV = 1; e.pid = mPid[idx];
        end
        pendEnt = 1; pendIdx = idx; pendSt = e.st;
      end else begin
        e.hcrV = 1;
        e.hcr  = {5'(mHcr[31:27] + 5'd1), mHcr[26:0]};
        pendHcrV = 1; pendHcr = e.hcr;
      end
    end
    dirWrData = data;
    dirWrEn   = 1'b1;
    q.push_back(e);
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rstN && !done) begin
        if (q.size() > 0) begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          checks++;
          ok = (entryWbValid == e.ent) && (hcrWbValid == e.hcrV) &&
               (physDeactValid == e.phV);
          if (e.ent)  ok = ok && (entryWbIdx == 2'(e.idx)) && (entryWbState == e.st);
          if (e.hcrV) ok = ok && (hcrWbData == e.hcr);
          if (e.phV)  ok = ok && (physDeactId == e.pid);
          if (!ok) begin
            fails++;
            $display("FAIL %s: act ent=%0b idx=%0d st=%b hcr=%0b/%h ph=%0b/%0d exp ent=%0b idx=%0d st=%b hcr=%0b/%h ph=%0b/%0d",
              e.tag, entryWbValid, entryWbIdx, entryWbState, hcrWbValid, hcrWbData,
              physDeactValid, physDeactId, e.ent, e.idx, e.st, e.hcrV, e.hcr, e.phV, e.pid);
          end
        end else begin
          checks++;
          if (entryWbValid || hcrWbValid || physDeactValid) begin
            fails++;
            $display("FAIL R10: act valids ent=%0b hcr=%0b ph=%0b exp all 0 with no write",
              entryWbValid, hcrWbValid, physDeactValid);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act run still going exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mState[i] = 2'b00; mVid[i] = '0; mHw[i] = 1'b0; mPid[i] = '0;
    end
    mHcr = 32'h0000_1234;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (entryWbValid || hcrWbValid || physDeactValid || entryWbIdx != 0 ||
        entryWbState != 0 || hcrWbData != 0 || physDeactId != 0) begin
      fails++;
      $display("FAIL R1: act outputs nonzero in reset exp all zero");
    end
    rstN = 1'b1;
    // setup
    mState[0] = 2'b10; mVid[0] = 24'd5;  mHw[0] = 1'b0; mPid[0] = 10'd0;
    mState[1] = 2'b11; mVid[1] = 24'd7;  mHw[1] = 1'b1; mPid[1] = 10'd33;
    mState[2] = 2'b10; mVid[2] = 24'd7;  mHw[2] = 1'b1; mPid[2] = 10'd44;
    mState[3] = 2'b01; mVid[3] = 24'd9;  mHw[3] = 1'b1; mPid[3] = 10'd100;
    idle(2);
    doWrite(32'd7, "R5 R6 R7 first match act+pend");
    doWrite(32'd7, "R5 R6 R7 second match active");
    doWrite(32'd5, "R8 non-hw hit");
    doWrite(32'd9, "R5 R9 pending-only misses");
    idle(2);
    mState[0] = 2'b10;
    doWrite(32'hAB00_0005, "R2 upper bits ignored");
    idle(2);
    mState[0] = 2'b10;
    splitMode = 1'b0;
    doWrite(32'd5, "R4 split off ignored");
    idle(1);
    splitMode = 1'b1;
    doWrite(32'd5, "R4 entry unchanged after ignored write");
    idle(2);
    mState[3] = 2'b10; mVid[3] = 24'd64; mHw[3] = 1'b0;
    doWrite(32'd64, "R3 id equal to count ignored");
    doWrite(32'd1020, "R3 special id ignored");
    idle(1);
    numIntr = 25'd65;
    doWrite(32'd64, "R3 id below count accepted");
    idle(2);
    mState[1] = 2'b10; mVid[1] = 24'd12; mHw[1] = 1'b1; mPid[1] = 10'd1020;
    doWrite(32'd12, "R8 special pid no request");
    idle(2);
    mState[1] = 2'b11; mPid[1] = 10'd1019;
    doWrite(32'd12, "R7 pid 1019 forwarded");
    idle(2);
    mHcr = 32'hF800_0055;
    doWrite(32'd30, "R9 counter wraps");
    doWrite(32'd31, "R10 back-to-back miss");
    doWrite(32'd32, "R10 back-to-back miss again");
    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule